// File: doc/BRIEF.md
# Double-Rate Burst-of-Two SRAM Read Pipeline

This block models the read side of a synchronous pipelined SRAM that has separate input and output data buses. It runs on one clock at twice the command rate. An internal phase bit divides the clock edges into "K-rise" edges and "K-bar" edges. Commands and addresses are sampled only on K-rise edges. The output `kr_phase` is high in each clock period whose closing edge is a K-rise edge. After reset the first active edge is always a K-rise edge, and the phase then alternates on every edge.

Each accepted read returns two words on `q_data`, one per half cycle, with `q_valid` marking them. The first word comes from the even address of the aligned pair and the second from the odd address. The input `lat_long` picks how soon the first word appears: one and a half command cycles (three edges) or one command cycle (two edges). Reads may be issued on every K-rise edge to form an unbroken stream. A burst already in flight always completes, even when no new read follows it.

The array is built from registers and has no reset. A backdoor write port loads it.

Top module: `ddr_b2_read_pipe`

## Requirements
- R1: A read is accepted only on a K-rise edge (`kr_phase` high in the period before the edge) with `cmd_read`=1 and `cmd_sel_n`=0. Any other combination on a K-rise edge is no read. Anything on a K-bar edge is also no read, and none of these produce output beats.
- R2: The address sampled with an accepted read is held in a read address register. The burst reads address `{rd_addr[AW-1:1],0}` first and `{rd_addr[AW-1:1],1}` second, so `rd_addr[0]` is ignored.
- R3: Each accepted read drives exactly two words on consecutive clock periods: the even-address word first, then the odd-address word.
- R4: With `lat_long`=1, the first word is valid in the period after the third edge following the command edge, counting the command edge as edge 0. The second word follows one period later.
- R5: With `lat_long`=0, the first word is valid after edge 2 and the second after edge 3.
- R6: Reads on consecutive K-rise edges give `q_valid` high in every period, with no gap between bursts.
- R7: When a K-rise edge carries no read, a burst accepted earlier still delivers both of its words.
- R8: `q_valid` is high exactly in the periods that carry a burst word. In all other periods `q_data` holds its previous value.
- R9: A synchronous active-low reset clears `q_valid`, `q_data` and every burst in flight, and sets the phase so the first edge after release is a K-rise edge. Memory contents are kept.
- R10: `bd_we`=1 writes `bd_wdata` to `bd_addr` on the clock edge. Reads accepted afterwards return the new value. `lat_long` may only change while no burst is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; alternate edges are K-rise and K-bar |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_long | input | 1 | 1: 1.5-cycle read latency, 0: 1-cycle latency |
| cmd_read | input | 1 | Read/write select, 1 = read |
| cmd_sel_n | input | 1 | Active-low command select |
| rd_addr | input | AW | Read address, sampled with a read |
| kr_phase | output | 1 | High when the next edge is a K-rise edge |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | AW | Backdoor write address |
| bd_wdata | input | WIDTH | Backdoor write data |
| q_valid | output | 1 | High while a burst word is on q_data |
| q_data | output | WIDTH | Read data output |

## Verification
Some behaviour is checked on every cycle by assertions:
- K-bar edges never disturb the captured command.
- A sampled read lands in the read address register.
- An even beat is always followed by its odd partner from the same pair.
- The output stage meets the selected latency and holds its data between beats.

Other behaviour only the bench scenarios can show: that the words returned match what was loaded, that streams have no gaps and isolated bursts drain, that a reset during a burst removes it while the memory survives, and that both latency modes line up with the command edge.

// File: rtl/rdp_pkg.sv
// Package: shared types for the double-rate burst read pipeline.
// Assumes one clock at twice the command rate; the phase type names the two
// kinds of edge.
package rdp_pkg;

    typedef enum logic {
        PH_KRISE = 1'b0,
        PH_KBAR  = 1'b1
    } half_e;

    typedef enum logic {
        LAT_ONE      = 1'b0,
        LAT_ONE_HALF = 1'b1
    } lat_e;

endpackage

// File: rtl/rdp_cmd_stage.sv
// Module: rdp_cmd_stage
// Tracks the half-cycle phase, samples read commands on K-rise edges and
// expands each accepted read into two beat addresses, one per edge.
// Assumes: synchronous active-low reset; after reset the first edge is K-rise.
module rdp_cmd_stage
    import rdp_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_read,
    input  logic          cmd_sel_n,
    input  logic [AW-1:0] rd_addr,
    output logic          kr_phase,
    output logic          beat_v,
    output logic [AW-1:0] beat_addr
);

    localparam int BW = AW - 1;

    half_e          ph;
    logic           rd_cmd;
    logic           cap_v;
    logic [BW-1:0]  cap_base;
    logic           brst_v;
    logic [BW-1:0]  brst_base;
    logic           addr_lsb_unused;

    assign addr_lsb_unused = rd_addr[0];
    assign kr_phase        = (ph == PH_KRISE);
    assign rd_cmd          = (ph == PH_KRISE) && cmd_read && !cmd_sel_n;

    // Alternate the phase on every edge, starting from K-rise after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_KRISE;
        else        ph <= (ph == PH_KRISE) ? PH_KBAR : PH_KRISE;
    end

    // Capture commands on K-rise edges and emit even then odd beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v     <= 1'b0;
            cap_base  <= '0;
            brst_v    <= 1'b0;
            brst_base <= '0;
            beat_v    <= 1'b0;
            beat_addr <= '0;
        end else if (ph == PH_KRISE) begin
            cap_v     <= rd_cmd;
            if (rd_cmd) cap_base <= rd_addr[AW-1:1];
            beat_v    <= brst_v;
            beat_addr <= {brst_base, 1'b1};
        end else begin
            beat_v    <= cap_v;
            beat_addr <= {cap_base, 1'b0};
            brst_v    <= cap_v;
            brst_base <= cap_base;
        end
    end

    AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (cap_v && cap_base == $past(rd_addr[AW-1:1]))); // R2

    AST_KBAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_KBAR) |=> ($stable(cap_v) && $stable(cap_base))); // R1

    AST_BURST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_v && !beat_addr[0]) |=>
            (beat_v && beat_addr[0] && beat_addr[AW-1:1] == $past(beat_addr[AW-1:1]))); // R3

endmodule

// File: rtl/rdp_mem_array.sv
// Module: rdp_mem_array
// Register-built storage with one backdoor write port and one asynchronous
// read port. Assumes the contents are not reset.
module rdp_mem_array #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 18,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             bd_we,
    input  logic [AW-1:0]    bd_addr,
    input  logic [WIDTH-1:0] bd_wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        // Load one word when the backdoor port addresses it.
        always_ff @(posedge clk) begin
            if (bd_we && bd_addr == AW'(w)) mem_q[w] <= bd_wdata;
        end
    end

    // Read the addressed word combinationally.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/rdp_out_stage.sv
// Module: rdp_out_stage
// Output register with selectable latency. The short path loads a beat one
// edge after it is issued, the long path two edges after. Assumes lat_long
// changes only while no beat is in flight.
module rdp_out_stage
    import rdp_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_long,
    input  logic             beat_v,
    input  logic [WIDTH-1:0] beat_data,
    output logic             q_valid,
    output logic [WIDTH-1:0] q_data
);

    logic             dly_v;
    logic [WIDTH-1:0] dly_data;
    logic             sel_v;
    logic [WIDTH-1:0] sel_data;
    lat_e             lat;

    assign lat = lat_e'(lat_long);

    // Extra half-cycle stage used only in the long-latency mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_v    <= 1'b0;
            dly_data <= '0;
        end else begin
            dly_v    <= beat_v;
            dly_data <= beat_data;
        end
    end

    // Pick the stage that feeds the output for the current mode.
    always_comb begin
        if (lat == LAT_ONE_HALF) begin
            sel_v    = dly_v;
            sel_data = dly_data;
        end else begin
            sel_v    = beat_v;
            sel_data = beat_data;
        end
    end

    // Output register: loads only on a beat, otherwise holds the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= sel_v;
            if (sel_v) q_data <= sel_data;
        end
    end

    AST_LAT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_long && beat_v) |=> q_valid); // R5

    AST_LAT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_long && beat_v) |=> ##1 q_valid); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> $stable(q_data)); // R8

endmodule

// File: rtl/ddr_b2_read_pipe.sv
// Module: ddr_b2_read_pipe (top)
// Burst-of-two read pipeline on a double-rate clock: command stage, register
// array and output stage with selectable latency.
// Assumes DEPTH >= 4 and a synchronous active-low reset.
module ddr_b2_read_pipe #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 18,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lat_long,
    input  logic             cmd_read,
    input  logic             cmd_sel_n,
    input  logic [AW-1:0]    rd_addr,
    output logic             kr_phase,
    input  logic             bd_we,
    input  logic [AW-1:0]    bd_addr,
    input  logic [WIDTH-1:0] bd_wdata,
    output logic             q_valid,
    output logic [WIDTH-1:0] q_data
);

    logic             beat_v;
    logic [AW-1:0]    beat_addr;
    logic [WIDTH-1:0] beat_data;

    rdp_cmd_stage #(.AW(AW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_read  (cmd_read),
        .cmd_sel_n (cmd_sel_n),
        .rd_addr   (rd_addr),
        .kr_phase  (kr_phase),
        .beat_v    (beat_v),
        .beat_addr (beat_addr)
    );

    rdp_mem_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
        .clk      (clk),
        .bd_we    (bd_we),
        .bd_addr  (bd_addr),
        .bd_wdata (bd_wdata),
        .rd_addr  (beat_addr),
        .rd_data  (beat_data)
    );

    rdp_out_stage #(.WIDTH(WIDTH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_long  (lat_long),
        .beat_v    (beat_v),
        .beat_data (beat_data),
        .q_valid   (q_valid),
        .q_data    (q_data)
    );

endmodule

// File: tb/ddr_b2_read_pipe_tb.sv
module ddr_b2_read_pipe_tb;

    localparam int DEPTH = 64;
    localparam int WIDTH = 18;
    localparam int AW    = 6;
    localparam int NEXP  = 8192;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             lat_long;
    logic             cmd_read;
    logic             cmd_sel_n;
    logic [AW-1:0]    rd_addr;
    logic             kr_phase;
    logic             bd_we;
    logic [AW-1:0]    bd_addr;
    logic [WIDTH-1:0] bd_wdata;
    logic             q_valid;
    logic [WIDTH-1:0] q_data;

    always #4 clk = ~clk;

    ddr_b2_read_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .lat_long(lat_long), .cmd_read(cmd_read),
        .cmd_sel_n(cmd_sel_n), .rd_addr(rd_addr), .kr_phase(kr_phase),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
        .q_valid(q_valid), .q_data(q_data)
    );

    logic [WIDTH-1:0] mem_m [DEPTH];
    bit               exp_v [NEXP];
    logic [WIDTH-1:0] exp_d [NEXP];
    int               e = 0;
    bit               ph_m = 1'b0;
    bit               mode_m = 1'b1;
    logic [WIDTH-1:0] last_q = '0;
    int               n_chk = 0;
    int               n_bad = 0;
    string            cur_req = "R3";

    function automatic logic [WIDTH-1:0] burst_word(logic [AW-1:0] a, bit hi);
        return mem_m[{a[AW-1:1], hi}];
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // One clock period: drive at negedge, model the edge, check at next negedge.
    task automatic step(bit rw, bit seln, logic [AW-1:0] a,
                        bit we, logic [AW-1:0] wa, logic [WIDTH-1:0] wd);
        bit kr;
        int lat;
        cmd_read = rw; cmd_sel_n = seln; rd_addr = a;
        bd_we = we; bd_addr = wa; bd_wdata = wd;
        kr = (ph_m == 1'b0);
        check(kr_phase == kr, "R9", "kr_phase", 32'(kr_phase), 32'(kr));
        @(posedge clk);
        e++;
        if (we) mem_m[wa] = wd;
        if (kr && rw && !seln) begin
            lat = mode_m ? 3 : 2;
            exp_v[e+lat]   = 1'b1; exp_d[e+lat]   = burst_word(a, 1'b0);
            exp_v[e+lat+1] = 1'b1; exp_d[e+lat+1] = burst_word(a, 1'b1);
        end
        ph_m = ~ph_m;
        @(negedge clk);
        if (exp_v[e]) begin
            check(q_valid && q_data == exp_d[e],
                  $sformatf("%s %s R8", cur_req, mode_m ? "R4" : "R5"), "beat",
                  {13'b0, q_valid, q_data}, {13'b0, 1'b1, exp_d[e]});
            last_q = exp_d[e];
        end else begin
            check(!q_valid && q_data == last_q, $sformatf("%s R8", cur_req), "idle hold",
                  {13'b0, q_valid, q_data}, {13'b0, 1'b0, last_q});
        end
        bd_we = 1'b0;
    endtask

    task automatic rd(bit rw, bit seln, logic [AW-1:0] a);
        step(rw, seln, a, 1'b0, '0, '0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) rd(1'b0, 1'b1, '0);
    endtask

    task automatic align();
        if (ph_m) idle(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_read = 1'b0; cmd_sel_n = 1'b1; bd_we = 1'b0;
        repeat (3) @(posedge clk);
        e += 3;
        for (int i = e + 1; i < NEXP; i++) exp_v[i] = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; ph_m = 1'b0; last_q = '0;
    endtask

    task automatic directed();
        // R7: a lone read with an odd address (R2), then deselect
        cur_req = "R7"; align(); rd(1'b1, 1'b0, 6'd5); idle(7);
        // R6: back-to-back reads on every K-rise edge
        cur_req = "R6"; align();
        for (int i = 0; i < 8; i++) begin
            rd(1'b1, 1'b0, 6'(i * 6 + 1)); rd(1'b1, 1'b0, 6'(i * 6 + 1));
        end
        idle(7);
        // R1: commands only on K-bar edges or with wrong encodings
        cur_req = "R1"; align();
        for (int i = 0; i < 4; i++) begin
            rd(1'b0, 1'b0, 6'(i)); rd(1'b1, 1'b0, 6'(i + 20));
            rd(1'b1, 1'b1, 6'(i)); rd(1'b1, 1'b0, 6'(i + 30));
        end
        idle(6);
    endtask

    initial begin
        lat_long = 1'b1; rd_addr = '0; bd_addr = '0; bd_wdata = '0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NEXP; i++) exp_v[i] = 1'b0;
        do_reset();
        // R9: reset state at the ports
        check(!q_valid && q_data == '0 && kr_phase, "R9", "reset state",
              {13'b0, q_valid, q_data}, 32'h0);
        // R10: backdoor preload
        cur_req = "R10";
        for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0, 1'b1, 6'(i), WIDTH'($urandom));
        idle(2);
        mode_m = 1'b1; lat_long = 1'b1; directed();
        mode_m = 1'b0; lat_long = 1'b0; directed();
        // R10: overwrite then read
        cur_req = "R10";
        step(1'b0, 1'b1, '0, 1'b1, 6'd10, 18'h2A5C3);
        idle(1); align(); rd(1'b1, 1'b0, 6'd11); idle(6);
        // R3 and R8 under random traffic, both modes
        for (int blk = 0; blk < 4; blk++) begin
            cur_req = "R3";
            idle(6);
            mode_m = blk[0]; lat_long = blk[0];
            for (int i = 0; i < 500; i++)
                rd(($urandom % 10) < 8, ($urandom % 10) < 2, 6'($urandom));
        end
        idle(6);
        // R9: reset during a burst drops it, memory is kept
        cur_req = "R9"; mode_m = 1'b1; lat_long = 1'b1;
        align(); rd(1'b1, 1'b0, 6'd40); rd(1'b1, 1'b0, 6'd40);
        do_reset(); idle(8);
        align(); rd(1'b1, 1'b0, 6'd40); idle(6);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule